// File: doc/BRIEF.md
# Transceiver Power-State Controller

This block decides, every cycle, which power state a Fast Ethernet transceiver sits in. It takes its requests from three bits of two management control words and from two hardware pins. From the highest-ranked request it drives the enables for the oscillator, the analog transmit, receive and PLL sections, the digital datapath, the management port and the MAC-side output drivers.

When the link-down saving state is active, a small sequencer also chooses between normal line signalling (link pulse bursts, idle or normal link pulses) and sparse probe pulses. If the link is down, normal signalling is replaced by one probe pulse every `PROBE_INTERVAL` clock cycles. Normal signalling returns once receive energy has persisted for `ENERGY_MIN` consecutive cycles, or once the link comes up.

The power-state encoding on `mode_o` is: 0 normal, 1 link-down saving, 2 analog off, 3 power-down, 4 isolate. Enable outputs follow the inputs in the same cycle. Only the sequencer holds state.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: With no request active, `mode_o`=0, all seven enables are 1, `norm_pulse_o`=1 and `probe_pulse_o`=0. Bits of the control words other than those named in R3 to R5 have no effect.
- R2: When `iso_pin_i`=1, `mode_o`=4 and every enable and both pulse outputs are 0, whatever the other requests are.
- R3: When `bas_ctrl_i[11]`=1 and isolate is not requested, `mode_o`=3, only `mgmt_en_o` is 1, and both pulse outputs are 0.
- R4: When `ext_ctrl_i[11]`=1 and no higher request is present, `mode_o`=2. In that state `osc_en_o`, `dig_en_o`, `mgmt_en_o` and `mac_oe_o` are 1, the three analog enables are 0, and both pulse outputs are 0.
- R5: When `ext_ctrl_i[12]`=1 or `ldps_pin_i`=1 and no higher request is present, `mode_o`=1 and all enables are 1. In the first cycle of this state `norm_pulse_o`=1.
- R6: In link-down saving with the link down and no energy, the block enters probing from the second cycle on. There `norm_pulse_o`=0, and `probe_pulse_o` is high for exactly one cycle in every `PROBE_INTERVAL`, first in cycle `PROBE_INTERVAL`-1 counted from 0.
- R7: While probing, `rx_energy_i` held high for `ENERGY_MIN` consecutive cycles restores `norm_pulse_o`=1 at the next cycle. Shorter bursts are ignored.
- R8: After waking, normal signalling stays on while energy or link is present. When both drop, probing restarts with the interval count from zero.
- R9: While probing, `link_up_i`=1 restores normal signalling at the next cycle.
- R10: `norm_pulse_o` and `probe_pulse_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_ctrl_i | input | 16 | Extended control word (bit 11 analog off, bit 12 link-down saving) |
| bas_ctrl_i | input | 16 | Basic control word (bit 11 power-down) |
| ldps_pin_i | input | 1 | Link-down saving strap |
| iso_pin_i | input | 1 | Isolate pin |
| link_up_i | input | 1 | Link status |
| rx_energy_i | input | 1 | Receive energy detect |
| osc_en_o | output | 1 | Oscillator enable |
| ana_tx_en_o | output | 1 | Analog transmit enable |
| ana_rx_en_o | output | 1 | Analog receive enable |
| pll_en_o | output | 1 | PLL enable |
| dig_en_o | output | 1 | Digital datapath enable |
| mgmt_en_o | output | 1 | Management port drive enable |
| mac_oe_o | output | 1 | MAC-side output drive enable |
| norm_pulse_o | output | 1 | Normal line signalling allowed |
| probe_pulse_o | output | 1 | Single-cycle probe pulse strobe |
| mode_o | output | 3 | Current power state |

## Verification
Several requests can be present in the same cycle: a register bit and a pin asking for link-down saving, or analog off together with power-down and isolate. The outcome then depends only on the ranking. The bench applies all 32 combinations of the five request sources, with unrelated control-word bits toggled alongside. For each combination it compares the enables and the state against a ranking computed on its own. The sequencer is then driven through probing, a short and a long energy burst, loss of energy and link recovery, with the probe spacing counted cycle by cycle.

// File: rtl/phy_pwr_pkg.sv
`timescale 1ns/1ps
package phy_pwr_pkg;
  typedef enum logic [2:0] {
    PM_NORMAL = 3'd0,
    PM_LDPS   = 3'd1,
    PM_ANAOFF = 3'd2,
    PM_PWRDN  = 3'd3,
    PM_ISO    = 3'd4
  } pwr_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PROBE = 2'd1,
    SQ_WAKE  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic osc;
    logic ana_tx;
    logic ana_rx;
    logic pll;
    logic dig;
    logic mgmt;
    logic mac;
  } pwr_en_t;

  localparam int unsigned ANAOFF_BIT = 11;
  localparam int unsigned LDPS_BIT   = 12;
  localparam int unsigned PWRDN_BIT  = 11;
endpackage

// File: rtl/pwr_mode_arb.sv
`timescale 1ns/1ps
module pwr_mode_arb
  import phy_pwr_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic [REG_W-1:0] ext_ctrl_i,
  input  logic [REG_W-1:0] bas_ctrl_i,
  input  logic             ldps_pin_i,
  input  logic             iso_pin_i,
  output pwr_mode_e        mode_o
);
  logic req_pwrdn, req_anaoff, req_ldps;

  assign req_pwrdn  = bas_ctrl_i[PWRDN_BIT];
  assign req_anaoff = ext_ctrl_i[ANAOFF_BIT];
  assign req_ldps   = ext_ctrl_i[LDPS_BIT] | ldps_pin_i;

  // fixed ranking: pin isolate over all register requests
  always_comb begin
    if (iso_pin_i)       mode_o = PM_ISO;
    else if (req_pwrdn)  mode_o = PM_PWRDN;
    else if (req_anaoff) mode_o = PM_ANAOFF;
    else if (req_ldps)   mode_o = PM_LDPS;
    else                 mode_o = PM_NORMAL;
  end
endmodule

// File: rtl/pwr_ldps_seq.sv
`timescale 1ns/1ps
module pwr_ldps_seq
  import phy_pwr_pkg::*;
#(
  parameter int unsigned PROBE_INTERVAL = 400000,
  parameter int unsigned ENERGY_MIN     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic link_up_i,
  input  logic rx_energy_i,
  output logic norm_pulse_o,
  output logic probe_pulse_o
);
  localparam int unsigned IV_W = $clog2(PROBE_INTERVAL + 1);
  localparam int unsigned EN_W = $clog2(ENERGY_MIN + 1);
  localparam logic [IV_W-1:0] IV_LAST = IV_W'(PROBE_INTERVAL - 1);
  localparam logic [EN_W-1:0] EN_LAST = EN_W'(ENERGY_MIN - 1);

  seq_state_e      st_q, st_d;
  logic [IV_W-1:0] iv_q, iv_d;
  logic [EN_W-1:0] en_q, en_d;
  logic            energy_ok, stay_probe;

  assign energy_ok = rx_energy_i && (en_q == EN_LAST);

  always_comb begin
    st_d = st_q;
    if (!active_i) st_d = SQ_IDLE;
    else begin
      unique case (st_q)
        SQ_IDLE:  st_d = link_up_i ? SQ_WAKE : SQ_PROBE;
        SQ_PROBE: if (link_up_i || energy_ok) st_d = SQ_WAKE;
        SQ_WAKE:  if (!link_up_i && !rx_energy_i) st_d = SQ_PROBE;
        default:  st_d = SQ_IDLE;
      endcase
    end
  end

  assign stay_probe = (st_q == SQ_PROBE) && (st_d == SQ_PROBE);

  always_comb begin
    iv_d = '0;
    en_d = '0;
    if (stay_probe) begin
      iv_d = (iv_q == IV_LAST) ? '0 : iv_q + 1'b1;
      en_d = rx_energy_i ? en_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE;
      iv_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      iv_q <= iv_d;
      en_q <= en_d;
    end
  end

  assign norm_pulse_o  = active_i && (st_q != SQ_PROBE);
  assign probe_pulse_o = active_i && (st_q == SQ_PROBE) && (iv_q == IV_LAST);

  // R10
  pulse_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(norm_pulse_o && probe_pulse_o));

  // R6
  probe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_pulse_o && PROBE_INTERVAL > 1) |=> !probe_pulse_o);

  // R7
  wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_PROBE && active_i && !link_up_i && !rx_energy_i) |=> (st_q != SQ_WAKE));
endmodule

// File: rtl/phy_pwr_ctrl.sv
`timescale 1ns/1ps
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int unsigned REG_W          = 16,
  parameter int unsigned PROBE_INTERVAL = 400000,
  parameter int unsigned ENERGY_MIN     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] ext_ctrl_i,
  input  logic [REG_W-1:0] bas_ctrl_i,
  input  logic             ldps_pin_i,
  input  logic             iso_pin_i,
  input  logic             link_up_i,
  input  logic             rx_energy_i,
  output logic             osc_en_o,
  output logic             ana_tx_en_o,
  output logic             ana_rx_en_o,
  output logic             pll_en_o,
  output logic             dig_en_o,
  output logic             mgmt_en_o,
  output logic             mac_oe_o,
  output logic             norm_pulse_o,
  output logic             probe_pulse_o,
  output logic [2:0]       mode_o
);
  pwr_mode_e mode;
  pwr_en_t   en;
  logic      seq_norm, seq_probe;

  pwr_mode_arb #(.REG_W(REG_W)) u_arb (
    .ext_ctrl_i (ext_ctrl_i),
    .bas_ctrl_i (bas_ctrl_i),
    .ldps_pin_i (ldps_pin_i),
    .iso_pin_i  (iso_pin_i),
    .mode_o     (mode)
  );

  pwr_ldps_seq #(
    .PROBE_INTERVAL (PROBE_INTERVAL),
    .ENERGY_MIN     (ENERGY_MIN)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .active_i      (mode == PM_LDPS),
    .link_up_i     (link_up_i),
    .rx_energy_i   (rx_energy_i),
    .norm_pulse_o  (seq_norm),
    .probe_pulse_o (seq_probe)
  );

  always_comb begin
    unique case (mode)
      PM_ISO:    en = '0;
      PM_PWRDN:  en = '{osc:1'b0, ana_tx:1'b0, ana_rx:1'b0, pll:1'b0, dig:1'b0, mgmt:1'b1, mac:1'b0};
      PM_ANAOFF: en = '{osc:1'b1, ana_tx:1'b0, ana_rx:1'b0, pll:1'b0, dig:1'b1, mgmt:1'b1, mac:1'b1};
      default:   en = '1;
    endcase
  end

  assign {osc_en_o, ana_tx_en_o, ana_rx_en_o, pll_en_o, dig_en_o, mgmt_en_o, mac_oe_o} = en;
  assign norm_pulse_o  = (mode == PM_NORMAL) | seq_norm;
  assign probe_pulse_o = seq_probe;
  assign mode_o        = mode;

  // R2
  iso_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_pin_i |-> !(mac_oe_o || mgmt_en_o || osc_en_o || dig_en_o || norm_pulse_o));

  // R3
  pwrdn_mgmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iso_pin_i && bas_ctrl_i[PWRDN_BIT]) |-> (mgmt_en_o && !dig_en_o && !osc_en_o && !mac_oe_o));

  // R4
  anaoff_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2) |-> (osc_en_o && dig_en_o && !pll_en_o && !ana_tx_en_o && !ana_rx_en_o));
endmodule

// File: tb/phy_pwr_ctrl_test.sv
`timescale 1ns/1ps
module phy_pwr_ctrl_test;
  localparam int PI = 5;
  localparam int EM = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [15:0] ext_ctrl, bas_ctrl;
  logic ldps_pin, iso_pin, link_up, rx_energy;
  logic osc_en, tx_en, rx_en, pll_en, dig_en, mgmt_en, mac_oe, norm_p, probe_p;
  logic [2:0] mode;

  phy_pwr_ctrl #(.REG_W(16), .PROBE_INTERVAL(PI), .ENERGY_MIN(EM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_ctrl_i(ext_ctrl), .bas_ctrl_i(bas_ctrl),
    .ldps_pin_i(ldps_pin), .iso_pin_i(iso_pin), .link_up_i(link_up), .rx_energy_i(rx_energy),
    .osc_en_o(osc_en), .ana_tx_en_o(tx_en), .ana_rx_en_o(rx_en), .pll_en_o(pll_en),
    .dig_en_o(dig_en), .mgmt_en_o(mgmt_en), .mac_oe_o(mac_oe),
    .norm_pulse_o(norm_p), .probe_pulse_o(probe_p), .mode_o(mode)
  );

  int n_vec = 0;
  int n_bad = 0;
  int wd = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_en(input int m);
    case (m)
      4:       return 7'b0000000;
      3:       return 7'b0000010;
      2:       return 7'b1000111;
      default: return 7'b1111111;
    endcase
  endfunction

  task automatic seq_chk(input string req, input logic en, input logic pr);
    #1;
    chk(req, {15'd0, norm_p}, {15'd0, en});
    chk(req, {15'd0, probe_p}, {15'd0, pr});
    chk("R10", {15'd0, norm_p & probe_p}, 16'd0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_ctrl = '0; bas_ctrl = '0;
    ldps_pin = 0; iso_pin = 0; link_up = 0; rx_energy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", {13'd0, mode}, 16'd0);
    chk("R1", {9'd0, osc_en, tx_en, rx_en, pll_en, dig_en, mgmt_en, mac_oe}, 16'h7F);
    chk("R1", {14'd0, norm_p, probe_p}, 16'b10);

    // all request combinations, with unrelated control bits toggled
    for (int v = 0; v < 32; v++) begin
      int em;
      string rq;
      @(negedge clk);
      iso_pin  = v[4];
      ldps_pin = v[0];
      ext_ctrl = ((16'(v) * 16'h0245) & ~16'h1800) | {3'b0, v[1], v[2], 11'd0};
      bas_ctrl = ((16'(v) * 16'h1103) & ~16'h0800) | {4'b0, v[3], 11'd0};
      em = v[4] ? 4 : v[3] ? 3 : v[2] ? 2 : (v[1] | v[0]) ? 1 : 0;
      rq = (em == 4) ? "R2" : (em == 3) ? "R3" : (em == 2) ? "R4" : (em == 1) ? "R5" : "R1";
      #1;
      chk(rq, {13'd0, mode}, 16'(em));
      chk(rq, {9'd0, osc_en, tx_en, rx_en, pll_en, dig_en, mgmt_en, mac_oe}, {9'd0, exp_en(em)});
      if (em != 1)
        chk(rq, {14'd0, norm_p, probe_p}, (em == 0) ? 16'b10 : 16'b00);
    end

    @(negedge clk);
    iso_pin = 0; ldps_pin = 0; ext_ctrl = '0; bas_ctrl = '0;
    @(negedge clk);
    @(negedge clk);
    ldps_pin = 1;
    seq_chk("R5", 1'b1, 1'b0);
    for (int k = 0; k < 3 * PI; k++) begin
      @(negedge clk);
      seq_chk("R6", 1'b0, (k % PI) == PI - 1);
    end

    // short burst ignored
    @(negedge clk); rx_energy = 1;
    #1 chk("R7", {15'd0, norm_p}, 16'd0);
    repeat (EM - 2) begin @(negedge clk); #1 chk("R7", {15'd0, norm_p}, 16'd0); end
    @(negedge clk); rx_energy = 0;
    #1 chk("R7", {15'd0, norm_p}, 16'd0);
    @(negedge clk); #1 chk("R7", {15'd0, norm_p}, 16'd0);

    // sustained energy wakes
    @(negedge clk); rx_energy = 1;
    #1 chk("R7", {15'd0, norm_p}, 16'd0);
    repeat (EM - 1) begin @(negedge clk); #1 chk("R7", {15'd0, norm_p}, 16'd0); end
    @(negedge clk); seq_chk("R7", 1'b1, 1'b0);
    repeat (4) begin @(negedge clk); seq_chk("R8", 1'b1, 1'b0); end

    // energy gone: probing restarts from zero
    @(negedge clk); rx_energy = 0;
    seq_chk("R8", 1'b1, 1'b0);
    for (int k = 0; k < 2 * PI; k++) begin
      @(negedge clk);
      seq_chk("R8", 1'b0, (k % PI) == PI - 1);
    end

    // link recovery
    @(negedge clk); link_up = 1;
    #1 chk("R9", {15'd0, norm_p}, 16'd0);
    @(negedge clk); seq_chk("R9", 1'b1, 1'b0);
    @(negedge clk); link_up = 0;
    seq_chk("R8", 1'b1, 1'b0);
    @(negedge clk); seq_chk("R8", 1'b0, 1'b0);

    // leave and re-enter via register bit
    @(negedge clk); ldps_pin = 0;
    #1 chk("R1", {13'd0, mode}, 16'd0);
    chk("R1", {14'd0, norm_p, probe_p}, 16'b10);
    @(negedge clk); ext_ctrl = 16'h1000;
    #1 chk("R5", {13'd0, mode}, 16'd1);
    chk("R5", {15'd0, norm_p}, 16'd1);
    for (int k = 0; k < PI; k++) begin
      @(negedge clk);
      seq_chk("R6", 1'b0, k == PI - 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule